// File: doc/BRIEF.md
# Peripheral Interrupt Gatherer

This block merges six peripheral interrupt requests into a single interrupt line for a processor. Each request input is watched for a low-to-high transition. A transition sets a sticky pending bit for that source. The bit stays set until the interrupt handler acknowledges that source on a dedicated per-source acknowledge input. Software can read the pending bits to find out which peripheral raised the shared line.

A per-source enable mask decides which pending bits reach the output. The mask is not written with a plain value. Each write carries a pair of bits for every source: one bit switches the enable off and the other switches it on. Software can therefore change one source's enable without reading the mask first and without disturbing the other sources.

A one-bit select picks whether the read port shows the pending bits or the mask. The interrupt output is registered.

Top module: `irq_gather`

## Requirements
- R1: While reset is asserted, and directly after it, the pending bits, the mask and `irq_o` are all 0.
- R2: A 0-to-1 change on `src_i[n]`, sampled at a clock edge, sets pending bit n at that edge. A source that stays high does not set the bit again. The reference for the first edge after reset is 0.
- R3: Pending bit n stays set until `ack_i[n]` is 1 at a clock edge; that edge clears it.
- R4: If `ack_i[n]` and a new rising change on `src_i[n]` happen at the same edge, pending bit n ends up set.
- R5: A write with `mask_wr_i`=1 and `mask_wdata_i[2n]`=1 (with bit 2n+1 = 0) disables source n. A write with bit 2n+1 = 1 (with bit 2n = 0) enables source n.
- R6: If bits 2n and 2n+1 are both 1 in a write, mask bit n keeps its value. If both are 0, mask bit n also keeps its value.
- R7: When `mask_wr_i` is 0, `mask_wdata_i` has no effect on the mask.
- R8: `rd_data_o` shows the pending bits when `rd_sel_i`=0 and the mask when `rd_sel_i`=1. Bit positions 0 to 5 are, in order: signal processor, serial link, audio, video, peripheral DMA, display processor.
- R9: `irq_o` equals, one clock later, the OR over all sources of (pending AND enabled).
- R10: A disabled source still latches its pending bit, and that bit is readable, but it does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Peripheral request inputs; a rising change marks an event |
| ack_i | input | 6 | Per-source acknowledge; clears the pending bit |
| mask_wr_i | input | 1 | Strobe for a mask write |
| mask_wdata_i | input | 12 | Mask write word; bit 2n disables source n, bit 2n+1 enables it |
| rd_sel_i | input | 1 | Read select: 0 selects pending bits, 1 selects the mask |
| rd_data_o | output | 6 | Read data |
| irq_o | output | 1 | Combined, registered interrupt request |

## Verification
The checker tests the following on every cycle:
- a rising source change sets its pending bit;
- an acknowledge without a coincident event clears the bit;
- each of the two mask-write encodings moves the enable in its own direction;
- a write with both bits or neither bit set, or no write at all, leaves the enable unchanged;
- `irq_o` follows the masked pending state with one cycle of lag.

Some behaviours only the bench scenarios can show. These are:
- the read multiplexer and the order of sources in the read word;
- the priority of a new event over an acknowledge at the same edge;
- a held-high source not firing again after it has been acknowledged;
- a masked but pending source becoming visible on `irq_o` once it is enabled.

The bench shows these through directed sequences and a randomized run compared against a behavioural model.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    localparam int unsigned SRC_COUNT = 6;
    localparam int unsigned WORD_PER_SRC = 2;

    typedef enum logic {
        RD_PENDING = 1'b0,
        RD_ENABLE  = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } bank_t;

    bank_t        s_d, s_q;
    logic [N-1:0] rise;

    // per-source edge detector and sticky bit; an event wins over an acknowledge
    for (genvar n = 0; n < N; n++) begin : g_src
        assign rise[n] = src_i[n] & ~s_q.prev[n];
    end

    always_comb begin
        s_d      = s_q;
        s_d.prev = src_i;
        s_d.pend = (s_q.pend & ~ack_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned N = 6,
    localparam int unsigned W = 2 * N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [N-1:0] mask_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } mask_t;

    mask_t        m_d, m_q;
    logic [N-1:0] turn_on, turn_off;

    // even bit disables, odd bit enables; both or neither keep the old value
    for (genvar n = 0; n < N; n++) begin : g_pair
        assign turn_off[n] = wr_i &  wdata_i[2*n] & ~wdata_i[2*n+1];
        assign turn_on[n]  = wr_i & ~wdata_i[2*n] &  wdata_i[2*n+1];
    end

    always_comb begin
        m_d    = m_q;
        m_d.en = (m_q.en & ~turn_off) | turn_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mask_o = m_q.en;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int unsigned N = SRC_COUNT,
    localparam int unsigned W = WORD_PER_SRC * N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] ack_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         rd_sel_i,
    output logic [N-1:0] rd_data_o,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } out_t;

    logic [N-1:0] pend_w;
    logic [N-1:0] mask_w;
    out_t         o_d, o_q;
    rd_sel_e      sel;

    irq_status_bank #(.N(N)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .ack_i  (ack_i),
        .pend_o (pend_w)
    );

    irq_mask_reg #(.N(N)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask_w)
    );

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(pend_w & mask_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sel       = rd_sel_e'(rd_sel_i);
    assign rd_data_o = (sel == RD_ENABLE) ? mask_w : pend_w;
    assign irq_o     = o_q.irq;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
    parameter int unsigned N = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   src_i,
    input logic [N-1:0]   ack_i,
    input logic           mask_wr_i,
    input logic [2*N-1:0] mask_wdata_i,
    input logic [N-1:0]   pend,
    input logic [N-1:0]   mask,
    input logic           irq_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && !irq_o));

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> (irq_o == $past(|(pend & mask))));

    for (genvar n = 0; n < N; n++) begin : g_chk
        // R2
        rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[n] && !$past(src_i[n])) |=> pend[n]);

        // R3
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ack_i[n] && !(src_i[n] && !$past(src_i[n]))) |=> !pend[n]);

        // R5
        enable_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_wr_i && mask_wdata_i[2*n+1] && !mask_wdata_i[2*n]) |=> mask[n]);

        // R5
        enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_wr_i && mask_wdata_i[2*n] && !mask_wdata_i[2*n+1]) |=> !mask[n]);

        // R6 R7
        enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!mask_wr_i || (mask_wdata_i[2*n] == mask_wdata_i[2*n+1])) |=> $stable(mask[n]));
    end
endmodule

bind irq_gather irq_gather_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src_i),
    .ack_i        (ack_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .pend         (pend_w),
    .mask         (mask_w),
    .irq_o        (irq_o)
);

// File: tb/irq_gather_test.sv
module irq_gather_test;
    localparam int N = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic [N-1:0]  ack = '0;
    logic          wr = 1'b0;
    logic [2*N-1:0] wdata = '0;
    logic          sel = 1'b0;
    logic [N-1:0]  rd_data;
    logic          irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference state
    bit [N-1:0] m_pend, m_mask, m_prev;
    bit         m_irq;

    always #4 clk = ~clk;

    irq_gather uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .ack_i        (ack),
        .mask_wr_i    (wr),
        .mask_wdata_i (wdata),
        .rd_sel_i     (sel),
        .rd_data_o    (rd_data),
        .irq_o        (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend <= '0; m_mask <= '0; m_prev <= '0; m_irq <= 1'b0;
        end else begin
            bit [N-1:0] np, nm;
            bit         any;
            np = m_pend; nm = m_mask; any = 0;
            for (int n = 0; n < N; n++) begin
                if (m_pend[n] && m_mask[n]) any = 1;
                if (src[n] && !m_prev[n]) np[n] = 1;
                else if (ack[n]) np[n] = 0;
                if (wr) begin
                    if (wdata[2*n+1] && !wdata[2*n]) nm[n] = 1;
                    if (wdata[2*n] && !wdata[2*n+1]) nm[n] = 0;
                end
            end
            m_irq  <= any;
            m_pend <= np;
            m_mask <= nm;
            m_prev <= src;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R9 irq vs model", irq, m_irq);
        chk(sel ? "R8 mask read vs model" : "R8 pending read vs model",
            rd_data, sel ? m_mask : m_pend);
    endtask

    // apply inputs after a falling edge, then sample at the next falling edge
    task automatic step(input bit [N-1:0] s, input bit [N-1:0] a,
                        input bit w, input bit [2*N-1:0] d, input bit rs);
        src = s; ack = a; wr = w; wdata = d; sel = rs;
        @(negedge clk);
        compare_model();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        sel = 0; #1; chk("R1 pending in reset", rd_data, 0);
        sel = 1; #1; chk("R1 mask in reset", rd_data, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_model();

        // R5: enable every source with the odd bits
        step('0, '0, 1, 12'hAAA, 1);
        chk("R5 enable all", rd_data, 6'h3F);

        // R2 R9: video (bit 3) pulse
        step(6'h08, '0, 0, '0, 0);
        chk("R2 video latched", rd_data, 6'h08);
        chk("R9 irq not yet", irq, 0);
        step('0, '0, 0, '0, 0);
        chk("R9 irq one cycle later", irq, 1);

        // R3: acknowledge clears
        step('0, 6'h08, 0, '0, 0);
        chk("R3 ack clears", rd_data, 0);
        step('0, '0, 0, '0, 0);
        chk("R3 irq drops", irq, 0);

        // R4: new event with ack at the same edge
        step(6'h01, '0, 0, '0, 0);
        step('0, '0, 0, '0, 0);
        step(6'h01, 6'h01, 0, '0, 0);
        chk("R4 event beats ack", rd_data, 6'h01);
        step('0, 6'h01, 0, '0, 0);
        chk("R3 later ack clears", rd_data, 0);

        // R6: both bits for audio (bits 4,5) keep the enable
        step('0, '0, 1, 12'h030, 1);
        chk("R6 both bits hold", rd_data, 6'h3F);
        step('0, '0, 1, 12'h000, 1);
        chk("R6 neither bit holds", rd_data, 6'h3F);
        // R5: disable audio through bit 4
        step('0, '0, 1, 12'h010, 1);
        chk("R5 disable audio", rd_data, 6'h3B);

        // R7: strobe low ignores data
        step('0, '0, 0, 12'h555, 1);
        chk("R7 no strobe no change", rd_data, 6'h3B);

        // R10: masked audio latches but stays quiet
        step(6'h04, '0, 0, '0, 0);
        chk("R10 masked pending readable", rd_data, 6'h04);
        step('0, '0, 0, '0, 0);
        chk("R10 masked no irq", irq, 0);
        step('0, '0, 1, 12'h020, 1);
        step('0, '0, 0, '0, 0);
        chk("R10 irq after enabling", irq, 1);
        step('0, 6'h04, 0, '0, 0);

        // R2: held-high source does not set the bit again after ack
        step(6'h02, '0, 0, '0, 0);
        step(6'h02, 6'h02, 0, '0, 0);
        step(6'h02, '0, 0, '0, 0);
        chk("R2 held high no refire", rd_data, 0);
        step('0, '0, 0, '0, 0);

        // randomized traffic against the model
        for (int i = 0; i < 400; i++) begin
            step(6'($urandom), 6'($urandom) & 6'($urandom),
                 ($urandom % 4) == 0, 12'($urandom), 1'($urandom));
        end

        // R1: reset mid-run
        rst_n = 1'b0;
        #1;
        sel = 0; #1; chk("R1 pending after reset", rd_data, 0);
        sel = 1; #1; chk("R1 mask after reset", rd_data, 0);
        chk("R1 irq after reset", irq, 0);
        finish_run();
    end
endmodule